// File: doc/BRIEF.md
# Display Window Update Sequencer

This block refreshes a rectangular area of a small display controller's frame memory. A host pulses `start` with a rectangle given as `x1`, `x2`, `y1`, `y2`, where the end coordinates are exclusive. The block then sends a fixed command sequence as a byte stream. Each byte carries a data/command flag for the serial link that follows. The sequence has three commands. The column-range command (0x2A) carries the first and last column. The row-range command (0x2B) carries the first and last row. The frame-write command (0x2C) is followed by the pixel payload. The pixel count comes from the rectangle.

Pixels arrive on a valid/ready stream. Each input word is either an RGB565 value in its low 16 bits or an XRGB8888 value that the block reduces to RGB565. A blanking request ignores the rectangle inputs. It covers the whole `PANEL_W` x `PANEL_H` panel and sends zero pixels without taking any input. A rectangle that is empty or reversed is refused with an error pulse.

Back-pressure rules:
- The output byte is registered. It stays valid and unchanged until `out_ready` is high at a clock edge.
- `pix_ready` is high only when the block can take a pixel's high byte into the output stage in that same cycle, so a stalled output holds off the pixel source.
- No byte is dropped or sent twice.

Top module: `dcs_window_seq`

## Requirements
- R1: After reset, `out_valid`, `busy`, `err`, `done` and `pix_ready` are all low.
- R2: A run opens with byte 0x2A flagged command (`out_dc`=0). Four parameter bytes flagged data (`out_dc`=1) follow: first column high byte, first column low byte, then high and low byte of `x2-1`.
- R3: Next comes byte 0x2B flagged command, followed by four data bytes in the same layout built from `y1` and `y2-1`.
- R4: Next comes byte 0x2C flagged command. Exactly 2*(x2-x1)*(y2-y1) data bytes follow it, and exactly (x2-x1)*(y2-y1) pixel words are taken from the input.
- R5: With `fmt_xrgb`=0, each pixel is `pix_data[15:0]`, sent high byte first, then low byte.
- R6: With `fmt_xrgb`=1, each pixel is {`pix_data[23:19]`, `pix_data[15:10]`, `pix_data[7:3]`}, sent high byte first.
- R7: With `blank`=1 at start, the window is columns 0..PANEL_W-1 and rows 0..PANEL_H-1. Every pixel byte is 0x00, and `pix_ready` stays low for the whole run.
- R8: A start with `blank`=0 and `x2`<=`x1` or `y2`<=`y1` gives a one-cycle `err` pulse in the next cycle. No byte is emitted and `busy` stays low.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_dc` hold their values into the next cycle.
- R10: `busy` is high from the cycle after an accepted start until the run ends. A `start` seen while busy is ignored and raises no `err`.
- R11: `done` pulses for one cycle in the cycle after the last byte is accepted. In that cycle `busy` and `out_valid` are already low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (sampled while idle) |
| blank | input | 1 | At start: clear the full panel instead of the rectangle |
| fmt_xrgb | input | 1 | At start: pixel words are XRGB8888 (1) or RGB565 (0) |
| x1 | input | COORD_W | First column |
| x2 | input | COORD_W | Column end, exclusive |
| y1 | input | COORD_W | First row |
| y2 | input | COORD_W | Row end, exclusive |
| busy | output | 1 | A run is in progress |
| err | output | 1 | One-cycle pulse: rectangle refused |
| done | output | 1 | One-cycle pulse: last byte accepted |
| pix_valid | input | 1 | Pixel word available |
| pix_ready | output | 1 | Pixel word taken this cycle when valid |
| pix_data | input | 32 | Pixel word |
| out_valid | output | 1 | Output byte available |
| out_ready | input | 1 | Link accepts the output byte |
| out_data | output | 8 | Output byte |
| out_dc | output | 1 | 0 = command byte, 1 = parameter or pixel byte |

## Verification
The bench uses windows whose last coordinate crosses a byte boundary, such as columns 0x00FE..0x0100. A design that takes the low byte of `x2` or forgets the minus-one would send a wrong parameter there. Single-pixel and single-row windows expose off-by-one errors in the pixel counter. Such an error shows up as a short or long payload, or as a pixel word taken without being sent. Random output stalls combined with a sparse pixel source catch a byte that is lost or repeated at the output register. A start injected mid-run must not disturb the stream or raise `err`. Blank runs must ignore the rectangle inputs and never assert `pix_ready`.

// File: rtl/dcs_seq_pkg.sv
package dcs_seq_pkg;
  localparam logic [7:0] CMD_COL_RANGE = 8'h2A;
  localparam logic [7:0] CMD_ROW_RANGE = 8'h2B;
  localparam logic [7:0] CMD_MEM_WRITE = 8'h2C;
  localparam int         HDR_BYTES     = 11;
  localparam int         HDR_IDX_W     = 4;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HDR,
    ST_PIX_HI,
    ST_PIX_LO,
    ST_DRAIN
  } seq_state_e;
endpackage

// File: rtl/dcs_geom.sv
// Validates the rectangle and derives inclusive bounds and pixel count.
module dcs_geom #(
  parameter int COORD_W = 16,
  parameter int PANEL_W = 240,
  parameter int PANEL_H = 320
) (
  input  logic                   blank,
  input  logic [COORD_W-1:0]     x1,
  input  logic [COORD_W-1:0]     x2,
  input  logic [COORD_W-1:0]     y1,
  input  logic [COORD_W-1:0]     y2,
  output logic                   ok,
  output logic [COORD_W-1:0]     col_first,
  output logic [COORD_W-1:0]     col_last,
  output logic [COORD_W-1:0]     row_first,
  output logic [COORD_W-1:0]     row_last,
  output logic [2*COORD_W-1:0]   npix
);
  localparam int CW2 = 2 * COORD_W;
  localparam logic [COORD_W-1:0] PW = COORD_W'(PANEL_W);
  localparam logic [COORD_W-1:0] PH = COORD_W'(PANEL_H);

  logic [COORD_W-1:0] width, height;

  always_comb begin
    if (blank) begin
      ok        = 1'b1;
      col_first = '0;
      row_first = '0;
      width     = PW;
      height    = PH;
    end else begin
      ok        = (x2 > x1) && (y2 > y1);
      col_first = x1;
      row_first = y1;
      width     = x2 - x1;
      height    = y2 - y1;
    end
    col_last = col_first + width - COORD_W'(1);
    row_last = row_first + height - COORD_W'(1);
    npix     = CW2'(width) * CW2'(height);
  end
endmodule

// File: rtl/dcs_hdr_gen.sv
// Selects one byte of the 11-byte window header by index.
module dcs_hdr_gen
  import dcs_seq_pkg::*;
#(
  parameter int COORD_W = 16
) (
  input  logic [HDR_IDX_W-1:0] idx,
  input  logic [COORD_W-1:0]   col_first,
  input  logic [COORD_W-1:0]   col_last,
  input  logic [COORD_W-1:0]   row_first,
  input  logic [COORD_W-1:0]   row_last,
  output logic [7:0]           hbyte,
  output logic                 hdc
);
  logic [15:0] cf, cl, rf, rl;

  always_comb begin
    cf  = 16'(col_first);
    cl  = 16'(col_last);
    rf  = 16'(row_first);
    rl  = 16'(row_last);
    hdc = 1'b1;
    case (idx)
      4'd0:    begin hbyte = CMD_COL_RANGE; hdc = 1'b0; end
      4'd1:    hbyte = cf[15:8];
      4'd2:    hbyte = cf[7:0];
      4'd3:    hbyte = cl[15:8];
      4'd4:    hbyte = cl[7:0];
      4'd5:    begin hbyte = CMD_ROW_RANGE; hdc = 1'b0; end
      4'd6:    hbyte = rf[15:8];
      4'd7:    hbyte = rf[7:0];
      4'd8:    hbyte = rl[15:8];
      4'd9:    hbyte = rl[7:0];
      default: begin hbyte = CMD_MEM_WRITE; hdc = 1'b0; end
    endcase
  end
endmodule

// File: rtl/dcs_px_pack.sv
// Reduces an input word to a 16-bit RGB565 pixel.
module dcs_px_pack (
  input  logic        fmt_xrgb,
  input  logic [31:0] word,
  output logic [15:0] rgb565
);
  logic unused_bits;
  assign unused_bits = ^{word[31:24], word[18:16]};

  always_comb begin
    if (fmt_xrgb) rgb565 = {word[23:19], word[15:10], word[7:3]};
    else          rgb565 = word[15:0];
  end
endmodule

// File: rtl/dcs_window_seq.sv
module dcs_window_seq
  import dcs_seq_pkg::*;
#(
  parameter int COORD_W = 16,
  parameter int PANEL_W = 240,
  parameter int PANEL_H = 320
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               blank,
  input  logic               fmt_xrgb,
  input  logic [COORD_W-1:0] x1,
  input  logic [COORD_W-1:0] x2,
  input  logic [COORD_W-1:0] y1,
  input  logic [COORD_W-1:0] y2,
  output logic               busy,
  output logic               err,
  output logic               done,
  input  logic               pix_valid,
  output logic               pix_ready,
  input  logic [31:0]        pix_data,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [7:0]         out_data,
  output logic               out_dc
);
  localparam int CW2 = 2 * COORD_W;
  localparam logic [HDR_IDX_W-1:0] HDR_LAST = HDR_IDX_W'(HDR_BYTES - 1);

  seq_state_e st;
  logic [HDR_IDX_W-1:0] hdr_idx;
  logic [COORD_W-1:0]   cf_q, cl_q, rf_q, rl_q;
  logic [CW2-1:0]       pix_left;
  logic                 blank_q, fmt_q;
  logic [7:0]           lo_q;

  logic                 g_ok;
  logic [COORD_W-1:0]   g_cf, g_cl, g_rf, g_rl;
  logic [CW2-1:0]       g_npix;
  logic [7:0]           h_byte;
  logic                 h_dc;
  logic [15:0]          px565;

  logic                 can_load, ld;
  logic [7:0]           ld_byte;
  logic                 ld_dc;

  dcs_geom #(.COORD_W(COORD_W), .PANEL_W(PANEL_W), .PANEL_H(PANEL_H)) u_geom (
    .blank(blank), .x1(x1), .x2(x2), .y1(y1), .y2(y2),
    .ok(g_ok), .col_first(g_cf), .col_last(g_cl),
    .row_first(g_rf), .row_last(g_rl), .npix(g_npix)
  );

  dcs_hdr_gen #(.COORD_W(COORD_W)) u_hdr (
    .idx(hdr_idx), .col_first(cf_q), .col_last(cl_q),
    .row_first(rf_q), .row_last(rl_q), .hbyte(h_byte), .hdc(h_dc)
  );

  dcs_px_pack u_pack (
    .fmt_xrgb(fmt_q), .word(pix_data), .rgb565(px565)
  );

  assign busy      = (st != ST_IDLE);
  assign can_load  = !out_valid || out_ready;
  assign pix_ready = (st == ST_PIX_HI) && !blank_q && can_load;

  // Byte offered to the output register this cycle.
  always_comb begin
    ld      = 1'b0;
    ld_byte = 8'h00;
    ld_dc   = 1'b1;
    case (st)
      ST_HDR: begin
        ld      = can_load;
        ld_byte = h_byte;
        ld_dc   = h_dc;
      end
      ST_PIX_HI: begin
        ld      = can_load && (blank_q || pix_valid);
        ld_byte = blank_q ? 8'h00 : px565[15:8];
      end
      ST_PIX_LO: begin
        ld      = can_load;
        ld_byte = lo_q;
      end
      default: ;
    endcase
  end

  // Output register stage.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= 8'h00;
      out_dc    <= 1'b0;
    end else if (ld) begin
      out_valid <= 1'b1;
      out_data  <= ld_byte;
      out_dc    <= ld_dc;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // Sequencer.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      hdr_idx  <= '0;
      cf_q     <= '0;
      cl_q     <= '0;
      rf_q     <= '0;
      rl_q     <= '0;
      pix_left <= '0;
      blank_q  <= 1'b0;
      fmt_q    <= 1'b0;
      lo_q     <= 8'h00;
      err      <= 1'b0;
      done     <= 1'b0;
    end else begin
      err  <= 1'b0;
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (start) begin
            if (g_ok) begin
              cf_q     <= g_cf;
              cl_q     <= g_cl;
              rf_q     <= g_rf;
              rl_q     <= g_rl;
              pix_left <= g_npix;
              blank_q  <= blank;
              fmt_q    <= fmt_xrgb;
              hdr_idx  <= '0;
              st       <= ST_HDR;
            end else begin
              err <= 1'b1;
            end
          end
        end
        ST_HDR: begin
          if (can_load) begin
            if (hdr_idx == HDR_LAST) st <= ST_PIX_HI;
            else                     hdr_idx <= hdr_idx + 1'b1;
          end
        end
        ST_PIX_HI: begin
          if (ld) begin
            lo_q <= blank_q ? 8'h00 : px565[7:0];
            st   <= ST_PIX_LO;
          end
        end
        ST_PIX_LO: begin
          if (can_load) begin
            pix_left <= pix_left - 1'b1;
            st       <= (pix_left == CW2'(1)) ? ST_DRAIN : ST_PIX_HI;
          end
        end
        ST_DRAIN: begin
          if (can_load) begin
            st   <= ST_IDLE;
            done <= 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dcs_window_seq_chk.sv
module dcs_window_seq_chk #(
  parameter int COORD_W = 16
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic               blank,
  input logic [COORD_W-1:0] x1,
  input logic [COORD_W-1:0] x2,
  input logic [COORD_W-1:0] y1,
  input logic [COORD_W-1:0] y2,
  input logic               busy,
  input logic               err,
  input logic               done,
  input logic               pix_ready,
  input logic               out_valid,
  input logic               out_ready,
  input logic [7:0]         out_data,
  input logic               out_dc
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_dc)));

  // R8
  bad_rect_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && !blank && ((x2 <= x1) || (y2 <= y1))) |=> (err && !busy));

  // R10
  start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && start && (blank || ((x2 > x1) && (y2 > y1)))) |=> busy);

  // R10
  ready_in_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> busy);

  // R11
  done_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && !out_valid && !err));
endmodule

bind dcs_window_seq dcs_window_seq_chk #(.COORD_W(COORD_W)) u_chk (.*);

// File: tb/dcs_window_seq_test.sv
module dcs_window_seq_test;
  localparam int CW = 16;
  localparam int PW = 8;
  localparam int PH = 4;

  logic clk = 1'b0;
  logic rst_n, start, blank, fmt_xrgb, pix_valid, out_ready;
  logic [CW-1:0] x1, x2, y1, y2;
  logic [31:0] pix_data;
  logic busy, err, done, pix_ready, out_valid, out_dc;
  logic [7:0] out_data;

  int checks = 0;
  int fails  = 0;

  logic [7:0]  exp_b [0:255];
  logic        exp_d [0:255];
  int          exp_n;
  logic [7:0]  got_b [0:255];
  logic        got_d [0:255];
  int          got_n;
  logic [31:0] pmem  [0:63];

  always #5 clk = ~clk;

  dcs_window_seq #(.COORD_W(CW), .PANEL_W(PW), .PANEL_H(PH)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .blank(blank), .fmt_xrgb(fmt_xrgb),
    .x1(x1), .x2(x2), .y1(y1), .y2(y2), .busy(busy), .err(err), .done(done),
    .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_dc(out_dc)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  function automatic logic [15:0] to565(input logic [31:0] w, input bit fx);
    return fx ? {w[23:19], w[15:10], w[7:3]} : w[15:0];
  endfunction

  task automatic push_exp(input logic [7:0] b, input logic d);
    exp_b[exp_n] = b;
    exp_d[exp_n] = d;
    exp_n++;
  endtask

  task automatic run_rect(input int ax1, input int ax2, input int ay1, input int ay2,
                          input bit fx, input bit bl, input int stall_pct, input bit poke);
    int cf, cl, rf, rl, np, pidx, cyc;
    bit done_seen, err_seen, rdy_seen, hold;
    logic [7:0] hold_b;
    logic hold_d;
    string preq;
    cf = bl ? 0 : ax1;   cl = bl ? PW - 1 : ax2 - 1;
    rf = bl ? 0 : ay1;   rl = bl ? PH - 1 : ay2 - 1;
    np = (cl - cf + 1) * (rl - rf + 1);
    preq = bl ? "R7" : (fx ? "R6" : "R5");
    exp_n = 0;
    push_exp(8'h2A, 1'b0);
    push_exp(8'(cf >> 8), 1'b1); push_exp(8'(cf), 1'b1);
    push_exp(8'(cl >> 8), 1'b1); push_exp(8'(cl), 1'b1);
    push_exp(8'h2B, 1'b0);
    push_exp(8'(rf >> 8), 1'b1); push_exp(8'(rf), 1'b1);
    push_exp(8'(rl >> 8), 1'b1); push_exp(8'(rl), 1'b1);
    push_exp(8'h2C, 1'b0);
    for (int i = 0; i < np; i++) begin
      pmem[i] = $urandom;
      if (bl) begin
        push_exp(8'h00, 1'b1); push_exp(8'h00, 1'b1);
      end else begin
        push_exp(to565(pmem[i], fx)[15:8], 1'b1);
        push_exp(to565(pmem[i], fx)[7:0], 1'b1);
      end
    end
    got_n = 0; pidx = 0; cyc = 0;
    done_seen = 0; err_seen = 0; rdy_seen = 0; hold = 0;
    hold_b = 8'h00; hold_d = 1'b0;
    while (!done_seen && cyc < 3000) begin
      @(negedge clk);
      start = (cyc == 0) || (poke && cyc == 6);
      if (cyc == 0) begin
        blank = bl; fmt_xrgb = fx;
        x1 = CW'(ax1); x2 = CW'(ax2); y1 = CW'(ay1); y2 = CW'(ay2);
      end else if (poke && cyc == 6) begin
        blank = 1'b0; x1 = 16'd9; x2 = 16'd9; y1 = 16'd1; y2 = 16'd0;
      end
      out_ready = (int'($urandom % 100) >= stall_pct);
      pix_valid = (int'($urandom % 100) < 70);
      pix_data  = (pidx < 64) ? pmem[pidx] : 32'h0;
      #3;
      if (cyc == 1) chk(busy == 1'b1, "R10 busy after start", busy, 1);
      if (hold) chk(out_valid && out_data == hold_b && out_dc == hold_d,
                    "R9 stalled byte held", out_data, hold_b);
      hold   = out_valid && !out_ready;
      hold_b = out_data;
      hold_d = out_dc;
      if (pix_ready) rdy_seen = 1;
      if (err) err_seen = 1;
      if (out_valid && out_ready && got_n < 256) begin
        got_b[got_n] = out_data;
        got_d[got_n] = out_dc;
        got_n++;
      end
      if (pix_valid && pix_ready) pidx++;
      if (done) begin
        done_seen = 1;
        chk(!busy && !out_valid, "R11 idle at done", {busy, out_valid}, 0);
      end
      cyc++;
    end
    @(negedge clk);
    start = 1'b0;
    #3;
    chk(done == 1'b0, "R11 done single pulse", done, 0);
    chk(done_seen, "R11 done seen", done_seen, 1);
    chk(got_n == exp_n, "R4 byte count", got_n, exp_n);
    for (int i = 0; i < 11 && i < got_n; i++)
      chk(got_b[i] == exp_b[i] && got_d[i] == exp_d[i],
          (i < 5) ? "R2 column header" : ((i < 10) ? "R3 row header" : "R4 write command"),
          {got_d[i], got_b[i]}, {exp_d[i], exp_b[i]});
    begin
      int bad;
      bad = -1;
      for (int i = 11; i < got_n && i < exp_n; i++)
        if (bad < 0 && (got_b[i] != exp_b[i] || got_d[i] != exp_d[i])) bad = i;
      if (bad < 0) chk(1'b1, preq, 0, 0);
      else chk(1'b0, preq, {got_d[bad], got_b[bad]}, {exp_d[bad], exp_b[bad]});
    end
    if (bl) chk(!rdy_seen, "R7 pix_ready low in blank", rdy_seen, 0);
    else    chk(pidx == np, "R4 pixel words taken", pidx, np);
    if (poke) chk(!err_seen, "R10 start while busy ignored", err_seen, 0);
  endtask

  task automatic bad_rect(input int ax1, input int ax2, input int ay1, input int ay2);
    bit any_out;
    @(negedge clk);
    start = 1'b1; blank = 1'b0; fmt_xrgb = 1'b0; out_ready = 1'b1; pix_valid = 1'b1;
    x1 = CW'(ax1); x2 = CW'(ax2); y1 = CW'(ay1); y2 = CW'(ay2);
    @(negedge clk);
    start = 1'b0;
    #3;
    chk(err == 1'b1, "R8 err pulse", err, 1);
    chk(busy == 1'b0, "R8 busy stays low", busy, 0);
    any_out = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      #3;
      if (out_valid || err || busy) any_out = 1;
    end
    chk(!any_out, "R8 no output after refusal", any_out, 0);
  endtask

  initial begin
    #2_000_000;
    checks++;
    fails++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; blank = 1'b0; fmt_xrgb = 1'b0;
    pix_valid = 1'b0; out_ready = 1'b0; pix_data = '0;
    x1 = '0; x2 = '0; y1 = '0; y2 = '0;
    repeat (3) @(negedge clk);
    #3;
    chk({out_valid, busy, err, done, pix_ready} == 5'b0, "R1 reset outputs",
        {out_valid, busy, err, done, pix_ready}, 0);
    @(negedge clk);
    rst_n = 1'b1;

    run_rect(16'h0123, 16'h0127, 16'h0200, 16'h0202, 1'b0, 1'b0, 0, 1'b0);
    run_rect(16'h00FE, 16'h0101, 5, 6, 1'b1, 1'b0, 40, 1'b0);
    run_rect(7, 8, 9, 10, 1'b0, 1'b0, 50, 1'b0);
    run_rect(3, 9, 2, 3, 1'b1, 1'b0, 20, 1'b1);
    run_rect(100, 50, 77, 80, 1'b0, 1'b1, 30, 1'b0);
    bad_rect(10, 10, 0, 4);
    bad_rect(5, 9, 6, 2);
    for (int t = 0; t < 8; t++) begin
      int rx, ry, rw, rh;
      rx = int'($urandom % 400);
      ry = int'($urandom % 400);
      rw = 1 + int'($urandom % 6);
      rh = 1 + int'($urandom % 5);
      run_rect(rx, rx + rw, ry, ry + rh, bit'($urandom % 2), 1'b0,
               int'($urandom % 60), 1'b0);
    end
    run_rect(0, 0, 0, 0, 1'b1, 1'b1, 55, 1'b1);
    summary();
  end
endmodule